// File: doc/BRIEF.md
# Contactless Receive Frame EMD Filter

This block sits between the byte decoder of a contactless reader and the buffer that stores received data. Each decoded byte arrives with its own parity-error, missing-parity and collision flags. Start and end pulses bound each frame, and a CRC verdict arrives with the end pulse. The block decides whether the frame is genuine data or electromagnetic disturbance (EMD) noise. It clears or keeps bits that follow a collision, removes CRC bytes unless told to keep them, and issues a write strobe per accepted byte followed by a one-cycle end-of-frame status.

A frame classed as disturbance leaves no trace: no byte strobes and no status. The receiver is ready for the next start pulse. To make that possible, the first four bytes of every frame are held back until the classification window has closed. Frames that end inside the window are flushed at the end pulse, one byte per cycle. Upstream must leave at least HOLD_DEPTH+2 idle cycles between an end pulse and the next start pulse, and the end pulse arrives in a cycle without a byte.

Top module: `rx_emd_filter`

## Requirements
- R1: Mode code 000, and the unused codes 101, 110 and 111, never suppress a frame: a parity error in any byte is reported through out_par_err and every byte is written.
- R2: Mode 001 drops a frame silently when it carries a parity error or a failed CRC and holds fewer than 4 bytes. Frames of 4 or more bytes with the same errors are written and reported.
- R3: Modes 010 (window 3) and 011/100 (window 4) drop a frame when a parity error or missing parity bit falls in a byte before the last window byte. They also drop a frame whose CRC fails and whose length does not exceed the window.
- R4: A parity error in the last window byte (byte 3 in mode 010, byte 4 in modes 011/100) drops the frame when cfg_par_emd is 1. Otherwise it is reported as a parity error.
- R5: In modes 011/100, a missing parity bit on byte 4 drops the frame when both cfg_adv_emd and cfg_miss_emd are 1. Otherwise, and in every other mode, a missing parity bit counts as a parity error.
- R6: Mode 100 also drops, silently, a frame of fewer than 4 bytes that has no parity or CRC error.
- R7: With cfg_coll_data at 1, a frame containing any collision flag reports out_data_err and not out_ok.
- R8: With cfg_keep_coll at 0, bits of the colliding byte above the flagged bit index (bits are numbered LSB first) and all bits of later bytes in the frame are written as 0. With it at 1, all bits keep their value.
- R9: A frame made of a single byte flagged partial is dropped silently when CRC checking is on and cfg_allow_bits is 0. Otherwise it is written, and it never reports a CRC error.
- R10: With CRC checking on and cfg_crc_to_mem at 0, the final 2 bytes of a frame are not written. With cfg_crc_to_mem at 1, they are written.
- R11: No byte of a frame is written before its 5th byte has been accepted or its end pulse has arrived. A dropped frame produces no write strobe and no out_done.
- R12: out_done is a single-cycle pulse that follows the last write of a kept frame and never coincides with out_wr. The status outputs are zero outside it, and out_ok is 1 exactly when none of the three error outputs is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Suppression mode code |
| cfg_par_emd | input | 1 | Parity error in last window byte counts as disturbance |
| cfg_adv_emd | input | 1 | Enables extended disturbance rules |
| cfg_miss_emd | input | 1 | Missing parity on byte 4 counts as disturbance |
| cfg_coll_data | input | 1 | Collision reported as data error |
| cfg_keep_coll | input | 1 | Keep bits after a collision (0 clears them) |
| cfg_crc_en | input | 1 | CRC checking on |
| cfg_allow_bits | input | 1 | Write sub-byte frames while CRC is on |
| cfg_crc_to_mem | input | 1 | Write CRC bytes too |
| in_sof | input | 1 | Frame start pulse |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | DATA_W | Decoded byte |
| in_par_err | input | 1 | Parity error on this byte |
| in_par_miss | input | 1 | Parity bit missing on this byte |
| in_coll | input | 1 | Collision in this byte |
| in_coll_pos | input | POS_W | Index of the collided bit |
| in_partial | input | 1 | Byte is incomplete |
| in_eof | input | 1 | Frame end pulse |
| in_crc_ok | input | 1 | CRC verdict, valid with in_eof |
| out_wr | output | 1 | Write strobe |
| out_byte | output | DATA_W | Byte to store |
| out_done | output | 1 | End-of-frame status strobe |
| out_ok | output | 1 | Frame error-free |
| out_par_err | output | 1 | Parity error reported |
| out_crc_err | output | 1 | CRC failure reported |
| out_data_err | output | 1 | Data-integrity error reported |

## Verification
The bench probes the window boundary: a parity error one byte before the window's last byte, on that byte, and one byte past it. A classifier off by one position would drop frames that should be reported, or leak noise into memory. It also aims at length edges, with frames of exactly 3 and 4 bytes in the length-based modes and a lone partial byte with CRC on. A wrong comparison there would either write short noise or lose genuine short frames. Collision masking is checked on a byte with the collision in its middle: a mask shifted by one bit changes the stored value. CRC stripping and the hold-back timing are checked by counting strobes before and after the fifth byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [2:0] MODE_OFF     = 3'd0;
  localparam logic [2:0] MODE_STD     = 3'd1;
  localparam logic [2:0] MODE_W3      = 3'd2;
  localparam logic [2:0] MODE_W4      = 3'd3;
  localparam logic [2:0] MODE_W4_DROP = 3'd4;
  localparam int         STD_MIN_LEN  = 4;

  typedef struct packed {
    logic ok;
    logic par;
    logic crc;
    logic data;
  } rxf_stat_t;

  // classification window length in bytes, 0 when the mode has none
  function automatic logic [2:0] window_of(input logic [2:0] mode);
    case (mode)
      MODE_W3:      return 3'd3;
      MODE_W4:      return 3'd4;
      MODE_W4_DROP: return 3'd4;
      default:      return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rxf_coll_mask.sv
module rxf_coll_mask #(
  parameter int DATA_W = 8,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              valid,
  input  logic [DATA_W-1:0] din,
  input  logic              coll,
  input  logic [POS_W-1:0]  pos,
  input  logic              keep,
  output logic [DATA_W-1:0] dout
);
  logic              after_q;
  logic [DATA_W-1:0] low_mask;

  always_ff @(posedge clk) begin
    if (rst || clr) after_q <= 1'b0;
    else if (valid && coll) after_q <= 1'b1;
  end

  // bits 0..pos survive in the colliding byte
  always_comb begin
    for (int i = 0; i < DATA_W; i++) low_mask[i] = (i <= int'(pos));
  end

  always_comb begin
    if (keep)         dout = din;
    else if (after_q) dout = '0;
    else if (coll)    dout = din & low_mask;
    else              dout = din;
  end
endmodule

// File: rtl/rxf_classifier.sv
module rxf_classifier
  import rxf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof,
  input  logic             valid,
  input  logic             par_err,
  input  logic             par_miss,
  input  logic             coll,
  input  logic             partial,
  input  logic             crc_ok,
  input  logic [2:0]       mode,
  input  logic             par_emd,
  input  logic             adv_emd,
  input  logic             miss_emd,
  input  logic             coll_data,
  input  logic             crc_en,
  input  logic             allow_bits,
  output logic             emd_now,
  output logic             fin_drop,
  output logic             fin_bitframe,
  output rxf_stat_t        fin_stat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(STD_MIN_LEN);

  logic [CNT_W-1:0] cnt_q, pos_k, win_n;
  logic             emd_q, par_q, coll_q, part_q;
  logic [2:0]       win;
  logic             perr, last_win, miss_rule;

  assign win       = window_of(mode);
  assign win_n     = CNT_W'(win);
  assign pos_k     = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign perr      = par_err || par_miss;
  assign last_win  = (win != 3'd0) && (pos_k == win_n);
  assign miss_rule = par_miss && (win == 3'd4) && adv_emd && miss_emd;

  always_ff @(posedge clk) begin
    if (rst || sof) begin
      cnt_q <= '0; emd_q <= 1'b0; par_q <= 1'b0; coll_q <= 1'b0; part_q <= 1'b0;
    end else if (valid) begin
      cnt_q  <= pos_k;
      coll_q <= coll_q | coll;
      part_q <= part_q | partial;
      if ((win != 3'd0) && (pos_k < win_n) && perr) emd_q <= 1'b1;
      else if (last_win) begin
        if (miss_rule || (par_err && par_emd)) emd_q <= 1'b1;
        else if (perr) par_q <= 1'b1;
      end else if (perr) par_q <= 1'b1;
    end
  end

  assign emd_now = emd_q;

  logic crc_bad, emd_fin, short_drop, bit_drop;
  always_comb begin
    fin_bitframe = (cnt_q == CNT_W'(1)) && part_q;
    crc_bad      = crc_en && !fin_bitframe && !crc_ok;
    if (mode == MODE_STD)  emd_fin = (par_q || crc_bad) && (cnt_q < MIN_LEN);
    else if (win != 3'd0)  emd_fin = emd_q || (crc_bad && (cnt_q <= win_n));
    else                   emd_fin = 1'b0;
    short_drop = (mode == MODE_W4_DROP) && !par_q && !crc_bad && (cnt_q < MIN_LEN);
    bit_drop   = crc_en && fin_bitframe && !allow_bits;
    fin_drop   = emd_fin || short_drop || bit_drop || (cnt_q == '0);
    fin_stat.par  = par_q;
    fin_stat.crc  = crc_bad;
    fin_stat.data = coll_data && coll_q;
    fin_stat.ok   = !(par_q || crc_bad || (coll_data && coll_q));
  end
endmodule

// File: rtl/rxf_hold.sv
module rxf_hold #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];

  assign head = mem[0];
  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (push) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
        mem[DEPTH-1] <= din;
      end else begin
        mem[count[IW-1:0]] <= din;
        count <= count + 1'b1;
      end
    end else if (pop && (count != '0)) begin
      for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rx_emd_filter.sv
module rx_emd_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POS_W      = $clog2(DATA_W),
  parameter int HOLD_DEPTH = 4,
  parameter int CRC_BYTES  = 2,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_par_emd,
  input  logic              cfg_adv_emd,
  input  logic              cfg_miss_emd,
  input  logic              cfg_coll_data,
  input  logic              cfg_keep_coll,
  input  logic              cfg_crc_en,
  input  logic              cfg_allow_bits,
  input  logic              cfg_crc_to_mem,
  input  logic              in_sof,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_par_err,
  input  logic              in_par_miss,
  input  logic              in_coll,
  input  logic [POS_W-1:0]  in_coll_pos,
  input  logic              in_partial,
  input  logic              in_eof,
  input  logic              in_crc_ok,
  output logic              out_wr,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_done,
  output logic              out_ok,
  output logic              out_par_err,
  output logic              out_crc_err,
  output logic              out_data_err
);
  localparam int CW = $clog2(HOLD_DEPTH + 1);
  localparam logic [CW-1:0] STRIP_MAX = CW'(CRC_BYTES);

  logic [DATA_W-1:0] masked, head;
  logic [CW-1:0]     hcount, strip_n, rem_q;
  logic              full, emd_now, fin_drop, fin_bitframe;
  logic              flushing_q, push, pop, hold_clr;
  rxf_stat_t         fin_stat, stat_q;

  rxf_coll_mask #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
    .clk(clk), .rst(rst), .clr(in_sof), .valid(in_valid), .din(in_byte),
    .coll(in_coll), .pos(in_coll_pos), .keep(cfg_keep_coll), .dout(masked)
  );

  rxf_classifier #(.CNT_W(CNT_W)) u_cls (
    .clk(clk), .rst(rst), .sof(in_sof), .valid(in_valid),
    .par_err(in_par_err), .par_miss(in_par_miss), .coll(in_coll),
    .partial(in_partial), .crc_ok(in_crc_ok), .mode(cfg_mode),
    .par_emd(cfg_par_emd), .adv_emd(cfg_adv_emd), .miss_emd(cfg_miss_emd),
    .coll_data(cfg_coll_data), .crc_en(cfg_crc_en), .allow_bits(cfg_allow_bits),
    .emd_now(emd_now), .fin_drop(fin_drop), .fin_bitframe(fin_bitframe),
    .fin_stat(fin_stat)
  );

  assign push     = in_valid && !flushing_q;
  assign pop      = flushing_q && (rem_q != '0);
  assign hold_clr = in_sof || (!flushing_q && in_eof && fin_drop) ||
                    (flushing_q && (rem_q == '0));

  rxf_hold #(.DATA_W(DATA_W), .DEPTH(HOLD_DEPTH), .CW(CW)) u_hold (
    .clk(clk), .rst(rst), .clear(hold_clr), .push(push), .pop(pop),
    .din(masked), .head(head), .count(hcount), .full(full)
  );

  always_comb begin
    if (cfg_crc_en && !cfg_crc_to_mem && !fin_bitframe)
      strip_n = (hcount > STRIP_MAX) ? STRIP_MAX : hcount;
    else
      strip_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wr <= 1'b0; out_byte <= '0; out_done <= 1'b0;
      out_ok <= 1'b0; out_par_err <= 1'b0; out_crc_err <= 1'b0; out_data_err <= 1'b0;
      flushing_q <= 1'b0; rem_q <= '0; stat_q <= '0;
    end else begin
      out_wr <= 1'b0; out_done <= 1'b0;
      out_ok <= 1'b0; out_par_err <= 1'b0; out_crc_err <= 1'b0; out_data_err <= 1'b0;
      if (flushing_q) begin
        if (rem_q != '0) begin
          out_wr   <= 1'b1;
          out_byte <= head;
          rem_q    <= rem_q - 1'b1;
        end else begin
          out_done     <= 1'b1;
          out_ok       <= stat_q.ok;
          out_par_err  <= stat_q.par;
          out_crc_err  <= stat_q.crc;
          out_data_err <= stat_q.data;
          flushing_q   <= 1'b0;
        end
      end else begin
        if (in_valid && full && !emd_now) begin
          out_wr   <= 1'b1;
          out_byte <= head;
        end
        if (in_eof && !fin_drop) begin
          flushing_q <= 1'b1;
          rem_q      <= hcount - strip_n;
          stat_q     <= fin_stat;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cfg_mode,
  input logic       in_sof,
  input logic       in_valid,
  input logic       in_eof,
  input logic       out_wr,
  input logic       out_done,
  input logic       out_ok,
  input logic       out_par_err,
  input logic       out_crc_err,
  input logic       out_data_err
);
  logic [2:0] in_cnt_q;
  logic       eof_seen_q;

  always_ff @(posedge clk) begin
    if (rst || in_sof) begin
      in_cnt_q <= '0; eof_seen_q <= 1'b0;
    end else begin
      if (in_valid && (in_cnt_q != 3'd7)) in_cnt_q <= in_cnt_q + 1'b1;
      if (in_eof) eof_seen_q <= 1'b1;
    end
  end

  assert_hold_window_R11: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> ((in_cnt_q >= 3'd5) || eof_seen_q));
  assert_done_apart_R12: assert property (@(posedge clk) disable iff (rst)
    out_done |-> !out_wr);
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);
  assert_status_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !out_done |-> !(out_ok || out_par_err || out_crc_err || out_data_err));
  assert_ok_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_ok) |-> !(out_par_err || out_crc_err || out_data_err));
  assert_short_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_ok && (cfg_mode == 3'd4)) |-> (in_cnt_q >= 3'd4));
endmodule

bind rx_emd_filter rxf_filter_chk u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .in_sof(in_sof),
  .in_valid(in_valid), .in_eof(in_eof), .out_wr(out_wr), .out_done(out_done),
  .out_ok(out_ok), .out_par_err(out_par_err), .out_crc_err(out_crc_err),
  .out_data_err(out_data_err)
);

// File: tb/sim_rx_emd_filter.sv
module sim_rx_emd_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [2:0] cfg_mode = 3'd0;
  logic cfg_par_emd = 0, cfg_adv_emd = 0, cfg_miss_emd = 0, cfg_coll_data = 0;
  logic cfg_keep_coll = 1, cfg_crc_en = 0, cfg_allow_bits = 0, cfg_crc_to_mem = 0;
  logic in_sof = 0, in_valid = 0, in_par_err = 0, in_par_miss = 0, in_coll = 0;
  logic in_partial = 0, in_eof = 0, in_crc_ok = 0;
  logic [7:0] in_byte = '0;
  logic [2:0] in_coll_pos = '0;
  logic out_wr, out_done, out_ok, out_par_err, out_crc_err, out_data_err;
  logic [7:0] out_byte;

  rx_emd_filter u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_par_emd(cfg_par_emd),
    .cfg_adv_emd(cfg_adv_emd), .cfg_miss_emd(cfg_miss_emd),
    .cfg_coll_data(cfg_coll_data), .cfg_keep_coll(cfg_keep_coll),
    .cfg_crc_en(cfg_crc_en), .cfg_allow_bits(cfg_allow_bits),
    .cfg_crc_to_mem(cfg_crc_to_mem), .in_sof(in_sof), .in_valid(in_valid),
    .in_byte(in_byte), .in_par_err(in_par_err), .in_par_miss(in_par_miss),
    .in_coll(in_coll), .in_coll_pos(in_coll_pos), .in_partial(in_partial),
    .in_eof(in_eof), .in_crc_ok(in_crc_ok), .out_wr(out_wr), .out_byte(out_byte),
    .out_done(out_done), .out_ok(out_ok), .out_par_err(out_par_err),
    .out_crc_err(out_crc_err), .out_data_err(out_data_err)
  );

  int n_chk = 0, n_bad = 0;
  int gn = 0, dn = 0, gbase = 0, dbase = 0;
  logic [7:0] got [64];
  logic [3:0] st_got = '0;

  logic [7:0] tx_b [8];
  logic       tx_pe [8], tx_pm [8], tx_co [8], tx_pt [8];
  logic [2:0] tx_cp [8];
  logic [7:0] exp_b [8];

  always @(negedge clk) begin
    if (out_wr) begin got[gn % 64] = out_byte; gn++; end
    if (out_done) begin dn++; st_got = {out_ok, out_par_err, out_crc_err, out_data_err}; end
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic cfg_default();
    cfg_mode = 3'd0; cfg_par_emd = 0; cfg_adv_emd = 0; cfg_miss_emd = 0;
    cfg_coll_data = 0; cfg_keep_coll = 1; cfg_crc_en = 0; cfg_allow_bits = 0;
    cfg_crc_to_mem = 0;
  endtask

  task automatic set_seq(input int n);
    for (int i = 0; i < 8; i++) begin
      tx_b[i] = 8'(8'h11 * (i + 1)); tx_pe[i] = 0; tx_pm[i] = 0;
      tx_co[i] = 0; tx_cp[i] = 0; tx_pt[i] = 0; exp_b[i] = tx_b[i];
    end
    if (n > 8) $display("bad length");
  endtask

  task automatic put_byte(input int i);
    in_valid = 1; in_byte = tx_b[i]; in_par_err = tx_pe[i]; in_par_miss = tx_pm[i];
    in_coll = tx_co[i]; in_coll_pos = tx_cp[i]; in_partial = tx_pt[i];
    @(posedge clk); #1;
    in_valid = 0; in_par_err = 0; in_par_miss = 0; in_coll = 0; in_partial = 0;
  endtask

  task automatic start_frame();
    gbase = gn; dbase = dn;
    in_sof = 1; @(posedge clk); #1; in_sof = 0;
  endtask

  task automatic end_frame(input bit crc_ok);
    in_eof = 1; in_crc_ok = crc_ok; @(posedge clk); #1; in_eof = 0; in_crc_ok = 0;
    repeat (14) @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input int n, input bit crc_ok);
    start_frame();
    for (int i = 0; i < n; i++) put_byte(i);
    end_frame(crc_ok);
  endtask

  // sexp = {ok, par, crc, data}
  task automatic expect_out(input string req, input int n, input bit done_exp,
                            input logic [3:0] sexp);
    chk((gn - gbase) == n, req, "write count", gn - gbase, n);
    for (int i = 0; i < n && i < (gn - gbase); i++)
      chk(got[(gbase + i) % 64] == exp_b[i], req, "byte value",
          int'(got[(gbase + i) % 64]), int'(exp_b[i]));
    chk((dn - dbase) == int'(done_exp), req, "done count", dn - dbase, int'(done_exp));
    if (done_exp && (dn - dbase) == 1)
      chk(st_got == sexp, req, "status {ok,par,crc,data}", int'(st_got), int'(sexp));
  endtask

  task automatic t_reset();
    chk(out_wr == 0 && out_done == 0, "R12", "reset outputs quiet", int'(out_wr | out_done), 0);
    chk(out_ok == 0, "R12", "reset ok low", int'(out_ok), 0);
  endtask

  task automatic t_mode_off_R1();
    cfg_default(); set_seq(5); run_frame(5, 1);
    expect_out("R1", 5, 1, 4'b1000);
    set_seq(3); tx_pe[1] = 1; run_frame(3, 1);
    expect_out("R1", 3, 1, 4'b0100);
    cfg_mode = 3'd5; run_frame(3, 1);
    expect_out("R1", 3, 1, 4'b0100);
    cfg_mode = 3'd7; run_frame(3, 1);
    expect_out("R1", 3, 1, 4'b0100);
  endtask

  task automatic t_mode_std_R2();
    cfg_default(); cfg_mode = 3'd1;
    set_seq(3); tx_pe[0] = 1; run_frame(3, 1);
    expect_out("R2", 0, 0, 4'b0000);
    set_seq(4); tx_pe[0] = 1; run_frame(4, 1);
    expect_out("R2", 4, 1, 4'b0100);
    cfg_crc_en = 1; cfg_crc_to_mem = 1; set_seq(3); run_frame(3, 0);
    expect_out("R2", 0, 0, 4'b0000);
  endtask

  task automatic t_window_R3();
    cfg_default(); cfg_mode = 3'd2;
    set_seq(6); tx_pe[1] = 1; run_frame(6, 1);
    expect_out("R3", 0, 0, 4'b0000);
    cfg_crc_en = 1; set_seq(3); run_frame(3, 0);
    expect_out("R3", 0, 0, 4'b0000);
    set_seq(5); run_frame(5, 0);
    expect_out("R3 R10", 3, 1, 4'b0010);
    cfg_default(); cfg_mode = 3'd3; set_seq(5); tx_pm[2] = 1; run_frame(5, 1);
    expect_out("R3", 0, 0, 4'b0000);
  endtask

  task automatic t_last_byte_R4();
    cfg_default(); cfg_mode = 3'd3;
    set_seq(5); tx_pe[3] = 1; run_frame(5, 1);
    expect_out("R4", 5, 1, 4'b0100);
    cfg_par_emd = 1; run_frame(5, 1);
    expect_out("R4", 0, 0, 4'b0000);
    cfg_mode = 3'd2; set_seq(5); tx_pe[2] = 1; run_frame(5, 1);
    expect_out("R4", 0, 0, 4'b0000);
    set_seq(5); tx_pe[3] = 1; run_frame(5, 1);
    expect_out("R4", 5, 1, 4'b0100);
  endtask

  task automatic t_missing_R5();
    cfg_default(); cfg_mode = 3'd3; cfg_adv_emd = 1; cfg_miss_emd = 1;
    set_seq(5); tx_pm[3] = 1; run_frame(5, 1);
    expect_out("R5", 0, 0, 4'b0000);
    cfg_miss_emd = 0; run_frame(5, 1);
    expect_out("R5", 5, 1, 4'b0100);
    cfg_miss_emd = 1; cfg_mode = 3'd2; run_frame(5, 1);
    expect_out("R5", 5, 1, 4'b0100);
  endtask

  task automatic t_short_R6();
    cfg_default(); cfg_mode = 3'd4;
    set_seq(3); run_frame(3, 1);
    expect_out("R6", 0, 0, 4'b0000);
    cfg_mode = 3'd3; run_frame(3, 1);
    expect_out("R6", 3, 1, 4'b1000);
    cfg_mode = 3'd4; set_seq(4); run_frame(4, 1);
    expect_out("R6", 4, 1, 4'b1000);
  endtask

  task automatic t_collision_R7_R8();
    cfg_default(); cfg_coll_data = 1;
    set_seq(3); tx_b[0] = 8'h5A; tx_b[1] = 8'hFF; tx_b[2] = 8'hAB;
    tx_co[1] = 1; tx_cp[1] = 3'd3;
    exp_b[0] = 8'h5A; exp_b[1] = 8'hFF; exp_b[2] = 8'hAB;
    run_frame(3, 1);
    expect_out("R7 R8", 3, 1, 4'b0001);
    cfg_keep_coll = 0; exp_b[1] = 8'h0F; exp_b[2] = 8'h00;
    run_frame(3, 1);
    expect_out("R8", 3, 1, 4'b0001);
    cfg_coll_data = 0; run_frame(3, 1);
    expect_out("R7 R8", 3, 1, 4'b1000);
  endtask

  task automatic t_bits_R9();
    cfg_default(); cfg_crc_en = 1;
    set_seq(1); tx_b[0] = 8'h05; tx_pt[0] = 1; exp_b[0] = 8'h05;
    run_frame(1, 0);
    expect_out("R9", 0, 0, 4'b0000);
    cfg_allow_bits = 1; run_frame(1, 0);
    expect_out("R9", 1, 1, 4'b1000);
    cfg_crc_en = 0; cfg_allow_bits = 0; run_frame(1, 0);
    expect_out("R9", 1, 1, 4'b1000);
  endtask

  task automatic t_crc_R10();
    cfg_default(); cfg_crc_en = 1;
    set_seq(5); run_frame(5, 1);
    expect_out("R10", 3, 1, 4'b1000);
    cfg_crc_to_mem = 1; run_frame(5, 1);
    expect_out("R10", 5, 1, 4'b1000);
  endtask

  task automatic t_holdback_R11();
    cfg_default(); set_seq(6);
    start_frame();
    for (int i = 0; i < 4; i++) put_byte(i);
    repeat (3) @(posedge clk);
    #1;
    chk((gn - gbase) == 0, "R11", "writes before byte 5", gn - gbase, 0);
    put_byte(4);
    @(posedge clk); #1;
    chk((gn - gbase) == 1, "R11", "writes after byte 5", gn - gbase, 1);
    chk(got[gbase % 64] == 8'h11, "R11", "first written byte", int'(got[gbase % 64]), 8'h11);
    put_byte(5);
    end_frame(1);
    expect_out("R11", 6, 1, 4'b1000);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1; rst = 0;
    @(posedge clk); #1;
    t_reset();
    t_mode_off_R1();
    t_mode_std_R2();
    t_window_R3();
    t_last_byte_R4();
    t_missing_R5();
    t_short_R6();
    t_collision_R7_R8();
    t_bits_R9();
    t_crc_R10();
    t_holdback_R11();
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    summary();
    $finish;
  end
endmodule